// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received Ethernet frame bytes into system memory. Memory holds a circular table of 8-byte receive descriptors, and the table begins at a programmable base address. For every buffer the engine first reads the descriptor's control word. It checks that the descriptor is handed to hardware, then reads the buffer pointer and streams the frame bytes into the buffer as 32-bit word writes. A buffer is closed when it reaches the programmed maximum length or when the frame ends. On closing, the engine writes the control word and length back and returns ownership to software.

The byte stream comes from a MAC through a valid/ready handshake with start-of-frame and end-of-frame markers. Error flags and address-recognition results are valid together with the end-of-frame byte. The engine raises single-cycle event pulses: one for a closed intermediate buffer, one for a completed frame, and one when it finds no free descriptor. Software builds the ring and chooses its length by placing the wrap flag. Descriptor and buffer addresses must be word aligned, and the maximum buffer length must be a nonzero multiple of four.

Top module: `rxbd_ring_engine`

## Requirements
- R1: A descriptor at address D is two big-endian words. D+0 holds a 16-bit control field in bits 31:16 and a 16-bit length in bits 15:0. D+4 holds the buffer pointer. Control bit 15 is hardware-owned, 14 is reserved (written 0), 13 is wrap, 12 is interrupt request, 11 is last, 10 is first, 9 is CAM miss, 8 is promiscuous-only accept, 7 is broadcast, 6 is multicast, and 5..0 carry the errors {length, non-octet, short, CRC, overrun, collision}. All memory accesses are word aligned.
- R2: If a fetched descriptor has the owned bit clear, the engine writes neither that descriptor nor any buffer. It pulses ev_busy once, discards the remaining bytes of the frame, and fetches the same descriptor again at the next frame start.
- R3: Closing a buffer rewrites control word D+0 with the owned bit and the reserved bit clear, and with the wrap and interrupt bits as they were fetched.
- R4: After a descriptor with the wrap bit set is closed, the next descriptor used is at the base address. Otherwise the next descriptor is at D+8.
- R5: A buffer that does not hold the final byte of its frame is closed after exactly the maximum buffer length. It carries that length, last=0, and all error and address bits 0.
- R6: The first bit is set only in the first buffer of a frame. The last bit is set in the buffer that receives the end-of-frame byte, and that buffer's length field holds the total octet count of the frame.
- R7: Error bits, broadcast, multicast and promiscuous-only bits are taken with the end-of-frame byte and are written only into the last buffer. The CAM miss bit is 1 only when CAM matching is enabled and the lookup missed.
- R8: Closing a buffer whose interrupt bit is 1 pulses ev_rxf for one cycle if the buffer is last, and ev_rxb for one cycle otherwise. A buffer with the interrupt bit 0 pulses neither. At most one event is high in any cycle.
- R9: Frame bytes are stored in arrival order at consecutive addresses from the buffer pointer, the first byte in bits 31:24. Byte strobes on a partial final word leave the bytes past the frame's end unchanged.
- R10: A memory request keeps its address, direction and data until mem_ack. rx_ready is low in every cycle with a pending memory request, and low out of reset.
- R11: When the end-of-frame byte also fills the buffer, that single buffer is closed as last with ev_rxf, and the next frame starts in the following descriptor.
- R12: When a frame needs another buffer and the next descriptor is not owned, the buffers already closed keep first/no-last with the maximum length. ev_busy pulses, and the rest of the frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | ADDR_W | Address of the first descriptor in the ring |
| cfg_buf_max | input | 16 | Maximum bytes per buffer (nonzero multiple of 4) |
| rx_valid | input | 1 | Byte on rx_data is valid |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 6 | Error flags {length, non-octet, short, CRC, overrun, collision}, valid with rx_eof |
| rx_bcast | input | 1 | Destination is broadcast, valid with rx_eof |
| rx_mcast | input | 1 | Destination is multicast, valid with rx_eof |
| rx_promisc | input | 1 | Frame accepted only through promiscuous mode, valid with rx_eof |
| rx_cam_en | input | 1 | CAM matching is enabled |
| rx_cam_miss | input | 1 | CAM lookup missed, valid with rx_eof |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte write strobes, bit 3 for bits 31:24 |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| ev_rxb | output | 1 | Intermediate buffer closed |
| ev_rxf | output | 1 | Frame completed |
| ev_busy | output | 1 | No owned descriptor available |

## Verification
Two events can coincide: the buffer reaching its maximum length and the frame ending, both on the same accepted byte. The bench provokes this with frames whose length is an exact multiple of the maximum buffer length, in directed cases and in random ones. It judges the outcome from the descriptor written back: last set, the total length, ev_rxf rather than ev_rxb, and the next frame landing in the next descriptor. A second pairing is a buffer filling while the next descriptor is not owned. Here the bench expects the closed buffer to be intermediate, together with a single busy event.

// File: rtl/rxbd_pkg.sv
`timescale 1ns/1ps
package rxbd_pkg;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int LEN_W     = 16;
  localparam int BD_STRIDE = 8;
  localparam int PTR_OFS   = 4;
  localparam int OWN_BIT   = WORD_W - 1;
  localparam int WRAP_BIT  = WORD_W - 3;
  localparam int IRQ_BIT   = WORD_W - 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BD_STAT,
    ST_BD_PTR,
    ST_FILL,
    ST_STORE,
    ST_CLOSE,
    ST_DROP
  } rx_state_e;

  typedef struct packed {
    logic       cam_miss;
    logic       promisc;
    logic       bcast;
    logic       mcast;
    logic [5:0] err;
  } frame_flags_t;

  function automatic logic [WORD_W-1:0] close_word(
    input logic             wrap,
    input logic             irq,
    input logic             last,
    input logic             first,
    input frame_flags_t     fl,
    input logic [LEN_W-1:0] len
  );
    logic [9:0] tail;
    tail = last ? fl : '0;
    return {1'b0, 1'b0, wrap, irq, last, first, tail, len};
  endfunction
endpackage

// File: rtl/rxbd_ring_ptr.sv
`timescale 1ns/1ps
module rxbd_ring_ptr
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  input  logic              wrap,
  output logic [ADDR_W-1:0] bd_addr
);
  logic              at_base_q, at_base_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  assign bd_addr = at_base_q ? base : ptr_q;

  always_comb begin
    at_base_d = at_base_q;
    ptr_d     = ptr_q;
    if (step) begin
      if (wrap) begin
        at_base_d = 1'b1;
      end else begin
        at_base_d = 1'b0;
        ptr_d     = bd_addr + ADDR_W'(BD_STRIDE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_base_q <= 1'b1;
      ptr_q     <= '0;
    end else if (step) begin
      at_base_q <= at_base_d;
      ptr_q     <= ptr_d;
    end
  end
endmodule

// File: rtl/rxbd_len_track.sv
`timescale 1ns/1ps
module rxbd_len_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             buf_start,
  input  logic             push,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] buf_cnt,
  output logic [LEN_W-1:0] frame_cnt,
  output logic             fill_hit
);
  logic [LEN_W-1:0] buf_d, frame_d;

  assign fill_hit = (buf_cnt + LEN_W'(1)) == max_len;

  always_comb begin
    buf_d   = buf_cnt;
    frame_d = frame_cnt;
    if (buf_start)   buf_d   = '0;
    if (frame_start) frame_d = '0;
    if (push) begin
      buf_d   = buf_cnt + LEN_W'(1);
      frame_d = frame_cnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_cnt   <= '0;
      frame_cnt <= '0;
    end else begin
      if (buf_start | push)   buf_cnt   <= buf_d;
      if (frame_start | push) frame_cnt <= frame_d;
    end
  end
endmodule

// File: rtl/rxbd_byte_packer.sv
`timescale 1ns/1ps
module rxbd_byte_packer #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                push,
  input  logic [7:0]          din,
  output logic [WORD_W-1:0]   word,
  output logic [WORD_W/8-1:0] strb,
  output logic                lane_last
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] lane_q;

  assign lane_last = (lane_q == LANE_W'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else if (clear) begin
      lane_q <= '0;
    end else if (push) begin
      lane_q <= lane_q + LANE_W'(1);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    logic       strb_q;
    logic       hit;

    assign hit = push && (lane_q == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (hit) begin
        byte_q <= din;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        strb_q <= 1'b0;
      end else if (clear) begin
        strb_q <= 1'b0;
      end else if (hit) begin
        strb_q <= 1'b1;
      end
    end

    assign word[WORD_W-1-8*g -: 8] = byte_q;
    assign strb[LANES-1-g]         = strb_q;
  end
endmodule

// File: rtl/rxbd_ring_engine.sv
`timescale 1ns/1ps
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [15:0]       cfg_buf_max,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [5:0]        rx_err,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  input  logic              rx_promisc,
  input  logic              rx_cam_en,
  input  logic              rx_cam_miss,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              ev_rxb,
  output logic              ev_rxf,
  output logic              ev_busy
);
  rx_state_e         state_q, state_d;
  logic [ADDR_W-1:0] bd_addr;
  logic [ADDR_W-1:0] dat_q;
  logic              bd_wrap_q, bd_irq_q;
  logic              first_q, end_q, full_q;
  frame_flags_t      flags_q, flags_in;
  logic              ev_rxb_q, ev_rxf_q, ev_busy_q;

  logic              push, pk_clear, frame_start, buf_start, ring_step;
  logic              own_hit, busy_hit, store_done, accept_eof;
  logic [WORD_W-1:0] pk_word;
  logic [LANES-1:0]  pk_strb;
  logic              lane_last;
  logic [LEN_W-1:0]  buf_cnt, frame_cnt;
  logic              fill_hit;

  rxbd_ring_ptr #(.ADDR_W(ADDR_W)) i_ring_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (cfg_ring_base),
    .step    (ring_step),
    .wrap    (bd_wrap_q),
    .bd_addr (bd_addr)
  );

  rxbd_len_track #(.LEN_W(LEN_W)) i_len_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .buf_start   (buf_start),
    .push        (push),
    .max_len     (cfg_buf_max),
    .buf_cnt     (buf_cnt),
    .frame_cnt   (frame_cnt),
    .fill_hit    (fill_hit)
  );

  rxbd_byte_packer #(.WORD_W(WORD_W)) i_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pk_clear),
    .push      (push),
    .din       (rx_data),
    .word      (pk_word),
    .strb      (pk_strb),
    .lane_last (lane_last)
  );

  assign flags_in = '{cam_miss: rx_cam_en & rx_cam_miss,
                      promisc:  rx_promisc,
                      bcast:    rx_bcast,
                      mcast:    rx_mcast,
                      err:      rx_err};

  // next-state and bus control
  always_comb begin
    state_d     = state_q;
    rx_ready    = 1'b0;
    push        = 1'b0;
    pk_clear    = 1'b0;
    frame_start = 1'b0;
    buf_start   = 1'b0;
    ring_step   = 1'b0;
    own_hit     = 1'b0;
    busy_hit    = 1'b0;
    store_done  = 1'b0;
    accept_eof  = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = bd_addr;
    mem_wdata   = '0;
    mem_wstrb   = '0;
    unique case (state_q)
      ST_IDLE: begin
        rx_ready = rx_valid & ~rx_sof;
        if (rx_valid && rx_sof) begin
          frame_start = 1'b1;
          state_d     = ST_BD_STAT;
        end
      end
      ST_BD_STAT: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          own_hit  = mem_rdata[OWN_BIT];
          busy_hit = ~mem_rdata[OWN_BIT];
          state_d  = mem_rdata[OWN_BIT] ? ST_BD_PTR : ST_DROP;
        end
      end
      ST_BD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = bd_addr + ADDR_W'(PTR_OFS);
        if (mem_ack) begin
          buf_start = 1'b1;
          pk_clear  = 1'b1;
          state_d   = ST_FILL;
        end
      end
      ST_FILL: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          push       = 1'b1;
          accept_eof = rx_eof;
          if (rx_eof || fill_hit || lane_last) state_d = ST_STORE;
        end
      end
      ST_STORE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dat_q;
        mem_wdata = pk_word;
        mem_wstrb = pk_strb;
        if (mem_ack) begin
          store_done = 1'b1;
          pk_clear   = 1'b1;
          state_d    = (end_q || full_q) ? ST_CLOSE : ST_FILL;
        end
      end
      ST_CLOSE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = close_word(bd_wrap_q, bd_irq_q, end_q, first_q, flags_q,
                               end_q ? frame_cnt : buf_cnt);
        mem_wstrb = '1;
        if (mem_ack) begin
          ring_step = 1'b1;
          state_d   = end_q ? ST_IDLE : ST_BD_STAT;
        end
      end
      ST_DROP: begin
        rx_ready = 1'b1;
        if (rx_valid && rx_eof) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bd_wrap_q <= 1'b0;
      bd_irq_q  <= 1'b0;
      dat_q     <= '0;
      first_q   <= 1'b0;
      end_q     <= 1'b0;
      full_q    <= 1'b0;
      flags_q   <= '0;
      ev_rxb_q  <= 1'b0;
      ev_rxf_q  <= 1'b0;
      ev_busy_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (own_hit) begin
        bd_wrap_q <= mem_rdata[WRAP_BIT];
        bd_irq_q  <= mem_rdata[IRQ_BIT];
      end
      if (buf_start) begin
        dat_q <= mem_rdata[ADDR_W-1:0];
      end else if (store_done) begin
        dat_q <= dat_q + ADDR_W'(LANES);
      end
      if (frame_start)    first_q <= 1'b1;
      else if (ring_step) first_q <= 1'b0;
      if (frame_start)     end_q <= 1'b0;
      else if (accept_eof) end_q <= 1'b1;
      if (buf_start)           full_q <= 1'b0;
      else if (push & fill_hit) full_q <= 1'b1;
      if (accept_eof) flags_q <= flags_in;
      ev_rxb_q  <= ring_step & bd_irq_q & ~end_q;
      ev_rxf_q  <= ring_step & bd_irq_q & end_q;
      ev_busy_q <= busy_hit;
    end
  end

  assign ev_rxb  = ev_rxb_q;
  assign ev_rxf  = ev_rxf_q;
  assign ev_busy = ev_busy_q;
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
`timescale 1ns/1ps
module rxbd_ring_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_wstrb,
  input logic              mem_ack,
  input logic [31:0]       mem_rdata,
  input logic              ev_rxb,
  input logic              ev_rxf,
  input logic              ev_busy
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_STALL_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready); // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R1

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_rxb, ev_rxf, ev_busy}) <= 1); // R8

  AST_EVENT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rxb || ev_rxf) |-> $past(mem_req && mem_we && mem_ack && (mem_wstrb == 4'hF))); // R8

  AST_BUSY_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |-> $past(mem_req && !mem_we && mem_ack && !mem_rdata[31])); // R2
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_ready  (rx_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_wstrb (mem_wstrb),
  .mem_ack   (mem_ack),
  .mem_rdata (mem_rdata),
  .ev_rxb    (ev_rxb),
  .ev_rxf    (ev_rxf),
  .ev_busy   (ev_busy)
);

// File: tb/test_rxbd_ring_engine.sv
`timescale 1ns/1ps
module test_rxbd_ring_engine;
  localparam int RING = 4;
  localparam int MAXL = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_ring_base;
  logic [15:0] cfg_buf_max;
  logic        rx_valid, rx_ready, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic [5:0]  f_err;
  logic        f_bc, f_mc, f_pm, f_cen, f_cm;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic        ev_rxb, ev_rxf, ev_busy;

  logic [31:0] mem [0:1023];
  logic [7:0]  fbytes [0:63];
  int          n_chk = 0, n_fail = 0;
  int          cnt_rxb = 0, cnt_rxf = 0, cnt_busy = 0;
  int          wcnt = 0;
  int          idx = 0;
  bit          armed [RING];
  bit          wcfg [RING] = '{1'b0, 1'b0, 1'b0, 1'b1};
  bit          icfg [RING] = '{1'b1, 1'b1, 1'b0, 1'b1};

  always #10 clk = ~clk;

  rxbd_ring_engine i_rxbd_ring_engine (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_buf_max(cfg_buf_max),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_err(f_err), .rx_bcast(f_bc), .rx_mcast(f_mc),
    .rx_promisc(f_pm), .rx_cam_en(f_cen), .rx_cam_miss(f_cm),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ev_rxb(ev_rxb), .ev_rxf(ev_rxf), .ev_busy(ev_busy)
  );

  // memory model with random wait states
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        wcnt      <= int'($urandom % 3);
      end else begin
        wcnt <= wcnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (ev_rxb)  cnt_rxb++;
      if (ev_rxf)  cnt_rxf++;
      if (ev_busy) cnt_busy++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int bd_w(input int k);
    return (32'h100 + 8 * k) >> 2;
  endfunction

  function automatic int buf_a(input int k);
    return 32'h400 + 64 * k;
  endfunction

  function automatic logic [7:0] get_byte(input int a);
    return mem[a >> 2][8 * (3 - (a % 4)) +: 8];
  endfunction

  task automatic arm(input int k);
    mem[bd_w(k)]     = {1'b1, 1'b0, wcfg[k], icfg[k], 12'h0, 16'h0};
    mem[bd_w(k) + 1] = buf_a(k);
    for (int j = 0; j < 16; j++) mem[(buf_a(k) >> 2) + j] = 32'hA5A5A5A5;
    armed[k] = 1'b1;
  endtask

  function automatic logic [31:0] parked(input int k);
    return {1'b0, 1'b0, wcfg[k], icfg[k], 12'h0, 16'hBEEF};
  endfunction

  task automatic disarm(input int k);
    mem[bd_w(k)] = parked(k);
    armed[k]     = 1'b0;
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbytes[i];
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      #1;
      while (!rx_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof   = 1'b0;
    rx_eof   = 1'b0;
  endtask

  task automatic run_frame(input int len, input string tag);
    int pos, n, k, e_rxb, e_rxf, e_busy;
    bit first, last;
    logic [15:0] st;
    for (int i = 0; i < len; i++) fbytes[i] = 8'($urandom);
    f_err = 6'($urandom);
    f_bc  = 1'($urandom);
    f_mc  = 1'($urandom);
    f_pm  = 1'($urandom);
    f_cen = 1'($urandom);
    f_cm  = 1'($urandom);
    e_rxb  = cnt_rxb;
    e_rxf  = cnt_rxf;
    e_busy = cnt_busy;
    send_frame(len);
    repeat (30) @(negedge clk);
    pos   = 0;
    first = 1'b1;
    while (1) begin
      k = idx;
      if (!armed[k]) begin
        chk({tag, " R2 unowned descriptor untouched"}, mem[bd_w(k)], parked(k));
        e_busy++;
        break;
      end
      n    = (len - pos > MAXL) ? MAXL : len - pos;
      last = (pos + n == len);
      st   = {1'b0, 1'b0, wcfg[k], icfg[k], last, first,
              last ? {f_cen & f_cm, f_pm, f_bc, f_mc, f_err} : 10'h0};
      chk({tag, " R1 R3 R5 R6 R7 close word"}, mem[bd_w(k)],
          {st, last ? 16'(len) : 16'(MAXL)});
      for (int j = 0; j < n; j++)
        chk({tag, " R9 data byte"}, 32'(get_byte(buf_a(k) + j)), 32'(fbytes[pos + j]));
      if (n % 4 != 0)
        chk({tag, " R9 byte past end kept"}, 32'(get_byte(buf_a(k) + n)), 32'hA5);
      if (icfg[k]) begin
        if (last) e_rxf++;
        else      e_rxb++;
      end
      armed[k] = 1'b0;
      idx      = wcfg[k] ? 0 : k + 1;  // R4 wrap to base
      pos      = pos + n;
      first    = 1'b0;
      if (last) break;
    end
    chk({tag, " R8 frame events"}, cnt_rxf, e_rxf);
    chk({tag, " R8 buffer events"}, cnt_rxb, e_rxb);
    chk({tag, " R2 busy events"}, cnt_busy, e_busy);
    for (int j = 0; j < RING; j++) if (!armed[j]) arm(j);
  endtask

  initial begin
    void'($urandom(32'd1729));
    rst_n         = 1'b0;
    rx_valid      = 1'b0;
    rx_sof        = 1'b0;
    rx_eof        = 1'b0;
    rx_data       = '0;
    f_err         = '0;
    f_bc          = 1'b0;
    f_mc          = 1'b0;
    f_pm          = 1'b0;
    f_cen         = 1'b0;
    f_cm          = 1'b0;
    cfg_ring_base = 32'h100;
    cfg_buf_max   = 16'(MAXL);
    for (int j = 0; j < 1024; j++) mem[j] = '0;
    for (int j = 0; j < RING; j++) arm(j);
    repeat (4) @(negedge clk);
    chk("R10 reset ready low", {31'h0, rx_ready}, 32'h0);
    chk("R10 reset no request", {31'h0, mem_req}, 32'h0);
    chk("R8 reset events low", {29'h0, ev_rxb, ev_rxf, ev_busy}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_frame(1, "single byte");
    run_frame(MAXL, "R11 end on full buffer");
    run_frame(MAXL + 1, "one past full");
    run_frame(2 * MAXL + 3, "three buffers R4");
    run_frame(2 * MAXL, "R11 two full buffers");
    for (int t = 0; t < 24; t++) run_frame(1 + int'($urandom % 26), "random");

    disarm(idx);
    run_frame(5, "R2 no buffer at start");
    run_frame(5, "R2 retry same descriptor");

    disarm(wcfg[idx] ? 0 : idx + 1);
    run_frame(2 * MAXL + 4, "R12 no buffer mid frame");
    run_frame(MAXL + 2, "after mid frame drop");

    summary();
    $finish;
  end
endmodule